// File: doc/BRIEF.md
# Eight-bit ALU with digit carry

This block is the arithmetic and logic unit of an 8-bit accumulator machine. It is purely combinational. Each operation takes the accumulator value (W), a second operand (a register or literal), the current carry flag and an operation code. It returns a result byte, a high product byte, and new values for the zero, carry and digit-carry flags. Each flag has its own update enable, so the surrounding datapath writes back only the flags that the operation defines.

Subtraction computes the operand minus W. Its carry is an inverted borrow: it is 1 when no borrow occurs. The digit carry is the carry out of the low nibble. A multiply places the low byte of its 16-bit product on the result and the high byte on a separate output. The register file, the choice of write-back target and 16-bit register-pair arithmetic belong to the caller.

The block has no states. The house preference for enumerated states therefore applies to the operation code. It is an enumerated type decoded with a unique case, with these named codes: ADD=0, ADDC=1, SUB=2, SUBC=3, SUBL=4, CMP=5, AND=6, OR=7, XOR=8, NOT=9, INC=10, DEC=11, RL=12, RR=13, SWAP=14, MULU=15, MULS=16, MOV=17. Codes 18 to 31 are undefined.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives result = W + operand. ADDC (code 1) adds the carry-in as well. The carry is the carry out of bit 7. The digit carry is the carry out of bit 3, counting the same carry-in. All three flags are enabled.
- R2: SUB (code 2) gives result = operand − W. SUBC (code 3) also subtracts a borrow equal to the inverse of the carry-in. The carry is 1 when the whole subtraction needs no borrow. The digit carry is 1 when the low-nibble subtraction, including that borrow, needs none. All three flags are enabled.
- R3: SUBL (code 4) gives result = operand − W, with the same carry and digit carry as SUB, but takes the zero flag from W − operand. CMP (code 5) sets the same three flags as SUBL and returns W unchanged as its result.
- R4: AND, OR, XOR (codes 6 to 8) combine W with the operand. NOT (9) inverts the operand. INC (10) and DEC (11) add or subtract one from the operand. MOV (17) passes the operand through. All of these enable only the zero flag.
- R5: RL (code 12) returns {operand[6:0], carry-in} and sets carry = operand[7]. RR (code 13) returns {carry-in, operand[7:1]} and sets carry = operand[0]. Only the carry flag is enabled.
- R6: SWAP (code 14) exchanges the operand's two nibbles and enables no flag.
- R7: MULU (code 15) multiplies W by the operand as unsigned 8-bit values. MULS (code 16) multiplies them as signed two's-complement values. The low product byte goes on the result and the high byte on the high output. No flag is enabled.
- R8: A flag whose enable is low is driven as 0. The high output is 0 for every operation except MULU and MULS.
- R9: The zero flag, where enabled, is 1 exactly when the value chosen for the zero test equals 0x00.
- R10: An undefined code (18 to 31) returns result 0, high byte 0 and no flag enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_i | input | 8 | Accumulator operand W |
| b_i | input | 8 | Second operand (register or literal) |
| c_i | input | 1 | Current carry flag |
| op_i | input | 5 | Operation code |
| res_o | output | 8 | Result byte (low product byte for multiply) |
| hi_o | output | 8 | High product byte |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| dc_o | output | 1 | New digit-carry flag |
| z_we_o | output | 1 | Zero flag update enable |
| c_we_o | output | 1 | Carry flag update enable |
| dc_we_o | output | 1 | Digit-carry update enable |

## Verification
The embedded assertions check these rules on every evaluation:
- disabled flags read as 0, and the high byte is 0 outside multiply;
- SWAP enables no flag;
- a rotate's carry equals the bit shifted out;
- the logic-operation zero flag matches the result;
- ADD with a zero operand returns W.

The bench's scenarios cover the rest, comparing every output with a behavioural model over corner vectors and a pseudo-random sweep of every code:
- the exact arithmetic values;
- the inverted-borrow and low-nibble carries, including the borrow taken from the carry-in;
- the reversed zero test of SUBL;
- signed versus unsigned products;
- the behaviour of undefined codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBC = 5'd3,
        OP_SUBL = 5'd4,
        OP_CMP  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_NOT  = 5'd9,
        OP_INC  = 5'd10,
        OP_DEC  = 5'd11,
        OP_RL   = 5'd12,
        OP_RR   = 5'd13,
        OP_SWAP = 5'd14,
        OP_MULU = 5'd15,
        OP_MULS = 5'd16,
        OP_MOV  = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic dc;
    } flag_set_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hcout_o
);
    localparam int NIB = W / 2;

    logic [W:0]   full_sum;
    logic [NIB:0] low_sum;

    // Full-width sum; the top bit is the carry out of the most significant bit
    assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    // Low half summed on its own to obtain the carry out of the low nibble
    assign low_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};

    assign sum_o   = full_sum[W-1:0];
    assign cout_o  = full_sum[W];
    assign hcout_o = low_sum[NIB];
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    generate
        if (SIGNED) begin : g_signed
            logic signed [2*W-1:0] a_ext;
            logic signed [2*W-1:0] b_ext;
            assign a_ext  = {{W{a_i[W-1]}}, a_i};
            assign b_ext  = {{W{b_i[W-1]}}, b_i};
            assign prod_o = a_ext * b_ext;
        end else begin : g_unsigned
            logic [2*W-1:0] a_ext;
            logic [2*W-1:0] b_ext;
            assign a_ext  = {{W{1'b0}}, a_i};
            assign b_ext  = {{W{1'b0}}, b_i};
            assign prod_o = a_ext * b_ext;
        end
    endgenerate
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] rl_o,
    output logic         rl_c_o,
    output logic [W-1:0] rr_o,
    output logic         rr_c_o,
    output logic [W-1:0] swap_o
);
    localparam int NIB = W / 2;

    assign rl_o   = {b_i[W-2:0], cin_i};
    assign rl_c_o = b_i[W-1];
    assign rr_o   = {cin_i, b_i[W-1:1]};
    assign rr_c_o = b_i[0];
    assign swap_o = {b_i[NIB-1:0], b_i[W-1:NIB]};
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] w_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    input  logic [4:0]   op_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] hi_o,
    output logic         z_o,
    output logic         c_o,
    output logic         dc_o,
    output logic         z_we_o,
    output logic         c_we_o,
    output logic         dc_we_o
);
    localparam int PW = 2 * W;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // Shared adder operand selection
    logic [W-1:0] add_a;
    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_hcout;

    always_comb begin
        add_a   = w_i;
        add_b   = b_i;
        add_cin = 1'b0;
        unique case (op)
            OP_ADD:  begin add_a = w_i; add_b = b_i;  add_cin = 1'b0; end
            OP_ADDC: begin add_a = w_i; add_b = b_i;  add_cin = c_i;  end
            OP_SUB, OP_SUBL, OP_CMP:
                     begin add_a = b_i; add_b = ~w_i; add_cin = 1'b1; end
            OP_SUBC: begin add_a = b_i; add_b = ~w_i; add_cin = c_i;  end
            OP_INC:  begin add_a = b_i; add_b = '0;   add_cin = 1'b1; end
            OP_DEC:  begin add_a = b_i; add_b = '1;   add_cin = 1'b0; end
            default: begin add_a = w_i; add_b = b_i;  add_cin = 1'b0; end
        endcase
    end

    alu8_adder #(.W(W)) u_adder (
        .a_i     (add_a),
        .b_i     (add_b),
        .cin_i   (add_cin),
        .sum_o   (add_sum),
        .cout_o  (add_cout),
        .hcout_o (add_hcout)
    );

    // Index 0 unsigned, index 1 signed
    logic [PW-1:0] prod [2];
    generate
        for (genvar k = 0; k < 2; k++) begin : g_mul
            alu8_mul #(.W(W), .SIGNED(k == 1)) u_mul (
                .a_i    (w_i),
                .b_i    (b_i),
                .prod_o (prod[k])
            );
        end
    endgenerate

    logic [W-1:0] rl_val;
    logic [W-1:0] rr_val;
    logic [W-1:0] swap_val;
    logic         rl_c;
    logic         rr_c;

    alu8_shift #(.W(W)) u_shift (
        .b_i    (b_i),
        .cin_i  (c_i),
        .rl_o   (rl_val),
        .rl_c_o (rl_c),
        .rr_o   (rr_val),
        .rr_c_o (rr_c),
        .swap_o (swap_val)
    );

    // Result, enables and raw flag sources
    logic [W-1:0] zsrc;
    flag_set_t    raw;
    flag_set_t    en;

    always_comb begin
        res_o = '0;
        hi_o  = '0;
        zsrc  = '0;
        raw   = '0;
        en    = '0;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
                res_o = add_sum;
                zsrc  = add_sum;
                raw   = '{z: 1'b0, c: add_cout, dc: add_hcout};
                en    = '{z: 1'b1, c: 1'b1, dc: 1'b1};
            end
            OP_SUBL: begin
                res_o = add_sum;
                // W - operand is zero exactly when operand - W is zero
                zsrc  = add_sum;
                raw   = '{z: 1'b0, c: add_cout, dc: add_hcout};
                en    = '{z: 1'b1, c: 1'b1, dc: 1'b1};
            end
            OP_CMP: begin
                res_o = w_i;
                zsrc  = add_sum;
                raw   = '{z: 1'b0, c: add_cout, dc: add_hcout};
                en    = '{z: 1'b1, c: 1'b1, dc: 1'b1};
            end
            OP_AND: begin res_o = w_i & b_i; zsrc = w_i & b_i; en.z = 1'b1; end
            OP_OR:  begin res_o = w_i | b_i; zsrc = w_i | b_i; en.z = 1'b1; end
            OP_XOR: begin res_o = w_i ^ b_i; zsrc = w_i ^ b_i; en.z = 1'b1; end
            OP_NOT: begin res_o = ~b_i;      zsrc = ~b_i;      en.z = 1'b1; end
            OP_INC, OP_DEC: begin
                res_o = add_sum;
                zsrc  = add_sum;
                en.z  = 1'b1;
            end
            OP_MOV: begin res_o = b_i; zsrc = b_i; en.z = 1'b1; end
            OP_RL:  begin res_o = rl_val; raw.c = rl_c; en.c = 1'b1; end
            OP_RR:  begin res_o = rr_val; raw.c = rr_c; en.c = 1'b1; end
            OP_SWAP: res_o = swap_val;
            OP_MULU: begin res_o = prod[0][W-1:0]; hi_o = prod[0][PW-1:W]; end
            OP_MULS: begin res_o = prod[1][W-1:0]; hi_o = prod[1][PW-1:W]; end
            default: res_o = '0;
        endcase
        raw.z = (zsrc == '0);
    end

    assign z_we_o  = en.z;
    assign c_we_o  = en.c;
    assign dc_we_o = en.dc;
    assign z_o     = en.z  & raw.z;
    assign c_o     = en.c  & raw.c;
    assign dc_o    = en.dc & raw.dc;

    // Embedded checks
    always_comb begin
        // R6
        if (op == OP_SWAP)
            swap_noflag_chk: assert (!z_we_o && !c_we_o && !dc_we_o)
                else $error("SWAP enabled a flag");
        // R8
        off_flag_zero_chk: assert ((z_we_o || !z_o) && (c_we_o || !c_o) && (dc_we_o || !dc_o))
            else $error("disabled flag driven high");
        // R8
        if (op != OP_MULU && op != OP_MULS)
            hi_idle_chk: assert (hi_o == '0)
                else $error("high byte nonzero outside multiply");
        // R5
        if (op == OP_RL)
            rl_carry_chk: assert (c_o == b_i[W-1] && res_o[0] == c_i)
                else $error("RL carry wrong");
        // R5
        if (op == OP_RR)
            rr_carry_chk: assert (c_o == b_i[0] && res_o[W-1] == c_i)
                else $error("RR carry wrong");
        // R9
        if (op == OP_AND || op == OP_OR || op == OP_XOR)
            logic_zero_chk: assert (z_o == (res_o == '0))
                else $error("logic zero flag wrong");
        // R1
        if (op == OP_ADD && b_i == '0)
            add_identity_chk: assert (res_o == w_i && !c_o && !dc_o)
                else $error("ADD of zero altered W");
    end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [7:0] w, b;
    logic       ci;
    logic [4:0] op;
    logic [7:0] res, hi;
    logic       z, c, dc, zwe, cwe, dcwe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u_dut (
        .w_i(w), .b_i(b), .c_i(ci), .op_i(op),
        .res_o(res), .hi_o(hi), .z_o(z), .c_o(c), .dc_o(dc),
        .z_we_o(zwe), .c_we_o(cwe), .dc_we_o(dcwe)
    );

    function automatic string req_of(int code);
        if (code <= 1) return "R1";
        if (code <= 3) return "R2";
        if (code <= 5) return "R3";
        if (code <= 11 || code == 17) return "R4";
        if (code <= 13) return "R5";
        if (code == 14) return "R6";
        if (code <= 16) return "R7";
        return "R10";
    endfunction

    task automatic chk(string rq, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic apply(int code, int wv, int bv, bit cv);
        int  r = 0, h = 0, zs = 0, brw;
        bit  ez = 0, ec = 0, ed = 0, fc = 0, fd = 0;
        byte sw, sb;
        @(posedge clk);
        op = code[4:0]; w = wv[7:0]; b = bv[7:0]; ci = cv;
        case (code)
            0, 1: begin
                r  = (wv + bv + ((code == 1) ? int'(cv) : 0));
                fc = r > 255;
                fd = ((wv % 16) + (bv % 16) + ((code == 1) ? int'(cv) : 0)) > 15;
                r  = r % 256; zs = r; ez = 1; ec = 1; ed = 1;
            end
            2, 3, 4, 5: begin
                brw = (code == 3) ? int'(!cv) : 0;
                r   = (bv - wv - brw + 512) % 256;
                fc  = bv >= wv + brw;
                fd  = (bv % 16) >= (wv % 16) + brw;
                zs  = (code >= 4) ? (wv - bv + 256) % 256 : r;
                if (code == 5) r = wv;
                ez = 1; ec = 1; ed = 1;
            end
            6:  begin r = wv & bv; zs = r; ez = 1; end
            7:  begin r = wv | bv; zs = r; ez = 1; end
            8:  begin r = wv ^ bv; zs = r; ez = 1; end
            9:  begin r = 255 - bv; zs = r; ez = 1; end
            10: begin r = (bv + 1) % 256; zs = r; ez = 1; end
            11: begin r = (bv + 255) % 256; zs = r; ez = 1; end
            17: begin r = bv; zs = r; ez = 1; end
            12: begin r = ((bv * 2) % 256) + int'(cv); fc = bv >= 128; ec = 1; end
            13: begin r = (bv / 2) + (cv ? 128 : 0); fc = (bv % 2) == 1; ec = 1; end
            14: r = ((bv % 16) * 16) + (bv / 16);
            15: begin r = (wv * bv) % 256; h = (wv * bv) / 256; end
            16: begin
                sw = wv[7:0]; sb = bv[7:0];
                r = (int'(sw) * int'(sb)) & 255;
                h = ((int'(sw) * int'(sb)) >>> 8) & 255;
            end
            default: ;
        endcase
        @(negedge clk);
        chk(req_of(code), "result", res, r);
        chk(req_of(code), "high byte", hi, h);
        chk(req_of(code), "enables", {zwe, cwe, dcwe}, {ez, ec, ed});
        chk("R9", "zero flag", z, ez && (zs == 0));
        chk("R8", "carry flag", c, ec && fc);
        chk("R8", "digit carry", dc, ed && fd);
    endtask

    initial begin
        int seed = 32'h1357;
        w = '0; b = '0; ci = 1'b0; op = '0;
        @(negedge clk);
        // R1 reset-like idle state: ADD 0+0
        chk("R1", "idle result", res, 0);
        chk("R1", "idle zero", z, 1);
        // R1 corner vectors: carries out of bit 3 and bit 7
        apply(0, 8'h0F, 8'h01, 0);
        apply(0, 8'hFF, 8'h01, 0);
        apply(1, 8'h7F, 8'h80, 1);
        apply(1, 8'h08, 8'h07, 1);
        // R2 borrow and no-borrow, borrow via carry-in
        apply(2, 8'h05, 8'h05, 0);
        apply(2, 8'h06, 8'h05, 1);
        apply(3, 8'h05, 8'h05, 0);
        apply(3, 8'h05, 8'h05, 1);
        apply(3, 8'h01, 8'h10, 1);
        // R3 reversed zero test and compare
        apply(4, 8'h33, 8'h33, 0);
        apply(4, 8'h10, 8'h33, 0);
        apply(5, 8'h40, 8'h41, 1);
        apply(5, 8'h41, 8'h41, 0);
        // R4 zero-only operations at boundaries
        apply(10, 0, 8'hFF, 1);
        apply(11, 0, 8'h00, 0);
        apply(9, 0, 8'hFF, 1);
        // R5 rotates with both carry-in values
        apply(12, 0, 8'h80, 0);
        apply(12, 0, 8'h01, 1);
        apply(13, 0, 8'h01, 0);
        apply(13, 0, 8'h80, 1);
        // R6 swap
        apply(14, 0, 8'hA5, 1);
        // R7 signed and unsigned extremes
        apply(15, 8'hFF, 8'hFF, 0);
        apply(16, 8'hFF, 8'hFF, 0);
        apply(16, 8'h80, 8'h7F, 1);
        apply(16, 8'h80, 8'h80, 0);
        // R10 undefined codes
        for (int k = 18; k < 32; k++) apply(k, 8'h12, 8'h34, 1);
        // Pseudo-random sweep across every defined code
        for (int n = 0; n < 30; n++) begin
            for (int k = 0; k < 18; k++) begin
                seed = seed * 1103515245 + 12345;
                apply(k, (seed >>> 8) & 255, (seed >>> 16) & 255, seed[20]);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule